// File: doc/BRIEF.md
# Indexed Postbyte Effective-Address Unit

This unit turns one indexed-mode postbyte into a final operand address for an 8-bit processor core with a 16-bit address space. The postbyte picks one of four pointer registers. It also picks the offset source: none, a 5-bit constant inside the postbyte, accumulator A or B, the 16-bit accumulator D, or an 8-bit or 16-bit constant from the instruction stream. It may ask for an automatic pointer step of 1 or 2, applied after the pointer is used (increment) or before (decrement). The updated pointer comes back on a write-back port, so the sequencer can store it in the register file.

The sequencer pulses `start` with the postbyte, the offset bytes already fetched, the accumulators, the program counter and the four pointers. The program counter must already point past every offset byte. In the long form, bit 4 of the postbyte asks for indirection. The unit then reads a 16-bit word at the computed address through a simple request/acknowledge port, and that word becomes the result. Every result carries the extra cycle count that the chosen mode adds to the instruction. Mode codes that are not defined raise an illegal flag instead of giving an address.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 choose the pointer: 00 selects X, 01 selects Y, 10 selects U and 11 selects S. The pointer that is written back is reported on `wb_sel` with the same code.
- R2: With postbyte bit 7 clear, the address is the pointer plus bits 4:0 read as a signed 5-bit value (range -16..+15). Bit 4 is then part of the offset and never means indirection. Extra cycles are 1, and there is no write-back.
- R3: With bit 7 set, mode code 0000 gives the pointer as address and writes back pointer+1. Code 0001 writes back pointer+2. Code 0010 gives pointer-1 as address and writes it back. Code 0011 does the same with pointer-2. Extra cycles are 2 for a step of 1 and 3 for a step of 2.
- R4: Code 0100 uses the pointer with no offset (0 extra cycles). Code 0101 adds B sign-extended and code 0110 adds A sign-extended (1 cycle each). Code 1011 adds D, formed as {A,B} (4 cycles).
- R5: Code 1000 adds the signed low byte of `offset`, and its high byte is ignored (1 cycle). Code 1001 adds all 16 bits of `offset` (4 cycles). Sums wrap modulo 2^16.
- R6: Codes 1100 and 1101 add the 8-bit or 16-bit offset to `pc_in` instead of a pointer, with 1 or 4 extra cycles. Bits 6:5 are ignored and there is no write-back.
- R7: With bit 7 and bit 4 both set, the unit reads a 16-bit word at the computed address. That word becomes `ea`, and 3 cycles are added to the mode's count. The request and its address stay stable until the acknowledge. Any pointer write-back of the mode still happens.
- R8: Codes 0111, 1010, 1110 and 1111, and the single-step codes 0000 and 0010 with bit 4 set, are illegal. The result then has `illegal`=1, `ea`=0, 0 extra cycles, no write-back and no memory read.
- R9: In a non-indirect case the result (`done` for one cycle) appears on the clock edge after the one that takes `start`. In an indirect case it appears on the edge after the acknowledge. `start` is ignored while a read is pending.
- R10: A synchronous active-low reset clears `done`, `ea`, `wb_en`, `illegal`, `extra_cyc` and any pending read, even in the middle of an indirect read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an address computation this cycle |
| postbyte | input | 8 | Indexed-mode postbyte |
| offset | input | 16 | Offset bytes from the instruction stream (8-bit form uses bits 7:0) |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| pc_in | input | 16 | Program counter after all offset bytes |
| ptr_x | input | 16 | Pointer X |
| ptr_y | input | 16 | Pointer Y |
| ptr_u | input | 16 | Pointer U |
| ptr_s | input | 16 | Pointer S |
| mem_rd_ack | input | 1 | Indirect read word is valid |
| mem_rd_data | input | 16 | Indirect read word |
| mem_rd_req | output | 1 | Indirect read request |
| mem_rd_addr | output | 16 | Indirect read address |
| done | output | 1 | Result valid, one cycle |
| ea | output | 16 | Effective address |
| illegal | output | 1 | Postbyte encodes an undefined mode |
| extra_cyc | output | 4 | Extra cycles added by the mode |
| wb_en | output | 1 | Pointer write-back valid (with `done`) |
| wb_sel | output | 2 | Pointer to write back |
| wb_val | output | 16 | Updated pointer value |

## Verification
The bench aims at the places where a sign or a carry is easy to lose. These are the 5-bit offset at -1 and -16, B = 0x80, an 8-bit offset whose high byte must be ignored, and 16-bit sums that wrap to zero. A decoder that zero-extended any of these would land 256 or 32 bytes away. The pre-decrement and post-increment modes check that the address uses the stepped pointer for decrement and the old pointer for increment. Swapping the two gives an address off by one or two while the write-back still looks correct. The indirect cases check the +3 cycle charge, that ++ still writes back, and that a second `start` during a pending read is dropped rather than producing two results. The illegal single-step indirect forms must neither issue a read nor write back.

// File: rtl/idx_ea_pkg.sv
// Shared types for the indexed effective-address unit.
// Assumes a fixed postbyte layout; only the address width is a parameter
// of the modules that use these types.
package idx_ea_pkg;

    localparam int IDX_CYC_W = 4;

    typedef enum logic [2:0] {
        OFS_NONE,
        OFS_SHORT,
        OFS_ACC_A,
        OFS_ACC_B,
        OFS_ACC_D,
        OFS_BYTE,
        OFS_WORD
    } idx_ofs_e;

    typedef struct packed {
        logic [1:0]           sel;       // pointer code
        logic                 base_pc;   // base is program counter
        idx_ofs_e             ofs;       // offset source
        logic [1:0]           step;      // auto step magnitude
        logic                 pre_dec;   // step is a decrement before use
        logic                 wb;        // pointer is written back
        logic                 ind;       // one level of indirection
        logic                 illegal;   // undefined encoding
        logic [IDX_CYC_W-1:0] cyc;       // extra cycles
    } idx_dec_t;

endpackage

// File: rtl/idx_postbyte_decode.sv
// Postbyte decoder: classifies one indexed postbyte into base, offset
// source, pointer step, indirection and extra-cycle cost.
// Purely combinational; assumes postbyte is stable while used.
module idx_postbyte_decode
    import idx_ea_pkg::*;
(
    input  logic [7:0] postbyte,
    output idx_dec_t   dec
);

    localparam logic [IDX_CYC_W-1:0] IND_CYC = IDX_CYC_W'(3);

    // Map mode code to decode fields
    always_comb begin
        dec         = '0;
        dec.sel     = postbyte[6:5];
        dec.ofs     = OFS_NONE;
        if (!postbyte[7]) begin
            dec.ofs = OFS_SHORT;
            dec.cyc = IDX_CYC_W'(1);
        end else begin
            dec.ind = postbyte[4];
            case (postbyte[3:0])
                4'b0000: begin dec.step = 2'd1; dec.wb = 1'b1; dec.cyc = IDX_CYC_W'(2);
                               dec.illegal = postbyte[4]; end
                4'b0001: begin dec.step = 2'd2; dec.wb = 1'b1; dec.cyc = IDX_CYC_W'(3); end
                4'b0010: begin dec.step = 2'd1; dec.pre_dec = 1'b1; dec.wb = 1'b1;
                               dec.cyc = IDX_CYC_W'(2); dec.illegal = postbyte[4]; end
                4'b0011: begin dec.step = 2'd2; dec.pre_dec = 1'b1; dec.wb = 1'b1;
                               dec.cyc = IDX_CYC_W'(3); end
                4'b0100: dec.cyc = '0;
                4'b0101: begin dec.ofs = OFS_ACC_B; dec.cyc = IDX_CYC_W'(1); end
                4'b0110: begin dec.ofs = OFS_ACC_A; dec.cyc = IDX_CYC_W'(1); end
                4'b1000: begin dec.ofs = OFS_BYTE;  dec.cyc = IDX_CYC_W'(1); end
                4'b1001: begin dec.ofs = OFS_WORD;  dec.cyc = IDX_CYC_W'(4); end
                4'b1011: begin dec.ofs = OFS_ACC_D; dec.cyc = IDX_CYC_W'(4); end
                4'b1100: begin dec.ofs = OFS_BYTE; dec.base_pc = 1'b1; dec.cyc = IDX_CYC_W'(1); end
                4'b1101: begin dec.ofs = OFS_WORD; dec.base_pc = 1'b1; dec.cyc = IDX_CYC_W'(4); end
                default: dec.illegal = 1'b1;
            endcase
            if (dec.ind) dec.cyc = dec.cyc + IND_CYC;
        end
    end

endmodule

// File: rtl/idx_addr_calc.sv
// Address arithmetic: selects the base, forms the sign- or zero-extended
// offset and applies the pointer step. Combinational.
// Assumes ADDR_W >= 16 so that D = {A,B} fits.
module idx_addr_calc
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  idx_dec_t                  dec,
    input  logic [7:0]                postbyte,
    input  logic [ADDR_W-1:0]         offset,
    input  logic [ADDR_W/2-1:0]       acc_a,
    input  logic [ADDR_W/2-1:0]       acc_b,
    input  logic [ADDR_W-1:0]         pc_in,
    input  logic [3:0][ADDR_W-1:0]    ptrs,
    output logic [ADDR_W-1:0]         addr,
    output logic [ADDR_W-1:0]         ptr_next
);

    localparam int ACC_W = ADDR_W / 2;

    logic [ADDR_W-1:0] ptr_cur;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs_val;
    logic [ADDR_W-1:0] delta;

    // Pick base and step amount
    always_comb begin
        ptr_cur = ptrs[dec.sel];
        base    = dec.base_pc ? pc_in : ptr_cur;
        delta   = {{(ADDR_W-2){1'b0}}, dec.step};
    end

    // Form the offset operand
    always_comb begin
        case (dec.ofs)
            OFS_SHORT: ofs_val = {{(ADDR_W-5){postbyte[4]}}, postbyte[4:0]};
            OFS_ACC_A: ofs_val = {{(ADDR_W-ACC_W){acc_a[ACC_W-1]}}, acc_a};
            OFS_ACC_B: ofs_val = {{(ADDR_W-ACC_W){acc_b[ACC_W-1]}}, acc_b};
            OFS_ACC_D: ofs_val = {acc_a, acc_b};
            OFS_BYTE:  ofs_val = {{(ADDR_W-8){offset[7]}}, offset[7:0]};
            OFS_WORD:  ofs_val = offset;
            default:   ofs_val = '0;
        endcase
    end

    // Apply step and offset
    always_comb begin
        ptr_next = dec.pre_dec ? (ptr_cur - delta) : (ptr_cur + delta);
        addr     = dec.pre_dec ? ptr_next : (base + ofs_val);
    end

endmodule

// File: rtl/idx_ea_unit.sv
// Indexed effective-address unit (top). Decodes the postbyte, computes the
// address and pointer update, and for indirect forms reads one word
// through a request/acknowledge port that must hold data valid with ack.
// Results are registered and presented with a one-cycle done pulse.
module idx_ea_unit
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [7:0]            postbyte,
    input  logic [ADDR_W-1:0]     offset,
    input  logic [ADDR_W/2-1:0]   acc_a,
    input  logic [ADDR_W/2-1:0]   acc_b,
    input  logic [ADDR_W-1:0]     pc_in,
    input  logic [ADDR_W-1:0]     ptr_x,
    input  logic [ADDR_W-1:0]     ptr_y,
    input  logic [ADDR_W-1:0]     ptr_u,
    input  logic [ADDR_W-1:0]     ptr_s,
    input  logic                  mem_rd_ack,
    input  logic [ADDR_W-1:0]     mem_rd_data,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    output logic                  done,
    output logic [ADDR_W-1:0]     ea,
    output logic                  illegal,
    output logic [IDX_CYC_W-1:0]  extra_cyc,
    output logic                  wb_en,
    output logic [1:0]            wb_sel,
    output logic [ADDR_W-1:0]     wb_val
);

    typedef enum logic {ST_IDLE, ST_FETCH} state_e;

    state_e                  state_q;
    idx_dec_t                dec;
    logic [3:0][ADDR_W-1:0]  ptrs;
    logic [ADDR_W-1:0]       calc_addr;
    logic [ADDR_W-1:0]       calc_ptr;
    logic                    wb_pend_q;

    assign ptrs = {ptr_s, ptr_u, ptr_y, ptr_x};

    idx_postbyte_decode u_dec (
        .postbyte (postbyte),
        .dec      (dec)
    );

    idx_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
        .dec      (dec),
        .postbyte (postbyte),
        .offset   (offset),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .pc_in    (pc_in),
        .ptrs     (ptrs),
        .addr     (calc_addr),
        .ptr_next (calc_ptr)
    );

    assign mem_rd_req = (state_q == ST_FETCH);

    // Sequence a computation and register its results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            done        <= 1'b0;
            ea          <= '0;
            illegal     <= 1'b0;
            extra_cyc   <= '0;
            wb_en       <= 1'b0;
            wb_sel      <= '0;
            wb_val      <= '0;
            wb_pend_q   <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    wb_sel <= dec.sel;
                    wb_val <= calc_ptr;
                    if (dec.illegal) begin
                        done      <= 1'b1;
                        illegal   <= 1'b1;
                        ea        <= '0;
                        extra_cyc <= '0;
                    end else if (dec.ind) begin
                        state_q     <= ST_FETCH;
                        mem_rd_addr <= calc_addr;
                        wb_pend_q   <= dec.wb;
                        extra_cyc   <= dec.cyc;
                        illegal     <= 1'b0;
                    end else begin
                        done      <= 1'b1;
                        illegal   <= 1'b0;
                        ea        <= calc_addr;
                        extra_cyc <= dec.cyc;
                        wb_en     <= dec.wb;
                    end
                end
                ST_FETCH: if (mem_rd_ack) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                    ea      <= mem_rd_data;
                    wb_en   <= wb_pend_q;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/idx_ea_unit_chk.sv
// Property checker for idx_ea_unit; observes ports only and is bound
// to every instance of the top module.
module idx_ea_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [7:0]        postbyte,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ack,
    input logic              done,
    input logic              illegal,
    input logic [3:0]        extra_cyc,
    input logic              wb_en,
    input logic [1:0]        wb_sel
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    wb_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !illegal));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R7
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack) |=> (done && !mem_rd_req));

    // R2
    short_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd_req && !postbyte[7])
        |=> (done && extra_cyc == 4'd1 && !wb_en && !illegal && !mem_rd_req));

    // R8
    undef_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd_req && postbyte[7] && postbyte[3:0] == 4'b0111)
        |=> (done && illegal && !mem_rd_req));

    // R1
    post_inc_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_rd_req && postbyte[7] && !postbyte[4] && postbyte[3:0] == 4'b0000)
        |=> (wb_en && wb_sel == $past(postbyte[6:5])));

endmodule

bind idx_ea_unit idx_ea_unit_chk #(.ADDR_W(ADDR_W)) u_idx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .postbyte    (postbyte),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .done        (done),
    .illegal     (illegal),
    .extra_cyc   (extra_cyc),
    .wb_en       (wb_en),
    .wb_sel      (wb_sel)
);

// File: tb/test_idx_ea_unit.sv
// Self-checking bench: vector table walk plus directed reset/timing tests.
module test_idx_ea_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam logic [15:0] PX = 16'h1000, PY = 16'h2000, PU = 16'h3000,
                            PS = 16'h4000, PPC = 16'h5000;

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  pb;
        logic [15:0] off;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] ea;
        logic        wb;
        logic [15:0] wbv;
        logic [3:0]  cyc;
        logic        ill;
    } vec_t;

    localparam int NV = 25;
    // memory model returns addr ^ 16'hA5A5
    localparam vec_t VECS [NV] = '{
        '{4'd2, 8'h05, 16'h0000, 8'h00, 8'h00, 16'h1005, 1'b0, 16'h0000, 4'd1, 1'b0}, // R2 +5
        '{4'd2, 8'h3F, 16'h0000, 8'h00, 8'h00, 16'h1FFF, 1'b0, 16'h0000, 4'd1, 1'b0}, // R2 -1, bit4 not indirect
        '{4'd1, 8'h50, 16'h0000, 8'h00, 8'h00, 16'h2FF0, 1'b0, 16'h0000, 4'd1, 1'b0}, // R1 U, -16
        '{4'd3, 8'h80, 16'h0000, 8'h00, 8'h00, 16'h1000, 1'b1, 16'h1001, 4'd2, 1'b0}, // R3 ,X+
        '{4'd3, 8'hA1, 16'h0000, 8'h00, 8'h00, 16'h2000, 1'b1, 16'h2002, 4'd3, 1'b0}, // R3 ,Y++
        '{4'd3, 8'hC2, 16'h0000, 8'h00, 8'h00, 16'h2FFF, 1'b1, 16'h2FFF, 4'd2, 1'b0}, // R3 ,-U
        '{4'd3, 8'hE3, 16'h0000, 8'h00, 8'h00, 16'h3FFE, 1'b1, 16'h3FFE, 4'd3, 1'b0}, // R3 ,--S
        '{4'd4, 8'h84, 16'h0000, 8'h00, 8'h00, 16'h1000, 1'b0, 16'h0000, 4'd0, 1'b0}, // R4 ,X
        '{4'd4, 8'h85, 16'h0000, 8'h00, 8'h80, 16'h0F80, 1'b0, 16'h0000, 4'd1, 1'b0}, // R4 B,X signed
        '{4'd4, 8'hA6, 16'h0000, 8'h7F, 8'h00, 16'h207F, 1'b0, 16'h0000, 4'd1, 1'b0}, // R4 A,Y
        '{4'd4, 8'hCB, 16'h0000, 8'h12, 8'h34, 16'h4234, 1'b0, 16'h0000, 4'd4, 1'b0}, // R4 D,U
        '{4'd5, 8'hE8, 16'h12FE, 8'h00, 8'h00, 16'h3FFE, 1'b0, 16'h0000, 4'd1, 1'b0}, // R5 8-bit, high byte ignored
        '{4'd5, 8'h89, 16'hF000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd4, 1'b0}, // R5 16-bit wrap
        '{4'd6, 8'hEC, 16'h0010, 8'h00, 8'h00, 16'h5010, 1'b0, 16'h0000, 4'd1, 1'b0}, // R6 PC 8-bit
        '{4'd6, 8'h8D, 16'h8000, 8'h00, 8'h00, 16'hD000, 1'b0, 16'h0000, 4'd4, 1'b0}, // R6 PC 16-bit
        '{4'd7, 8'h94, 16'h0000, 8'h00, 8'h00, 16'hB5A5, 1'b0, 16'h0000, 4'd3, 1'b0}, // R7 [,X]
        '{4'd7, 8'hB1, 16'h0000, 8'h00, 8'h00, 16'h85A5, 1'b1, 16'h2002, 4'd6, 1'b0}, // R7 [,Y++]
        '{4'd7, 8'h9D, 16'h0100, 8'h00, 8'h00, 16'hF4A5, 1'b0, 16'h0000, 4'd7, 1'b0}, // R7 [PC16]
        '{4'd7, 8'h98, 16'h0020, 8'h00, 8'h00, 16'hB585, 1'b0, 16'h0000, 4'd4, 1'b0}, // R7 [8,X]
        '{4'd8, 8'h87, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b1}, // R8 0111
        '{4'd8, 8'h8A, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b1}, // R8 1010
        '{4'd8, 8'h8E, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b1}, // R8 1110
        '{4'd8, 8'h8F, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b1}, // R8 1111
        '{4'd8, 8'h90, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b1}, // R8 [,X+]
        '{4'd8, 8'hB2, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b1}  // R8 [,-Y]
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [15:0] offset = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        mem_rd_ack = 1'b0;
    logic [15:0] mem_rd_data;
    logic        mem_rd_req, done, illegal, wb_en;
    logic [15:0] mem_rd_addr, ea, wb_val;
    logic [3:0]  extra_cyc;
    logic [1:0]  wb_sel;

    int n_chk = 0, n_fail = 0, rd_count = 0, age = 0, cyc_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_ea_unit i_idx_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .offset(offset), .acc_a(acc_a), .acc_b(acc_b), .pc_in(PPC),
        .ptr_x(PX), .ptr_y(PY), .ptr_u(PU), .ptr_s(PS),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .done(done), .ea(ea), .illegal(illegal), .extra_cyc(extra_cyc),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
    );

    assign mem_rd_data = mem_rd_addr ^ 16'hA5A5;

    // Memory model: acknowledge on the second cycle a request is seen
    always @(negedge clk) begin
        if (!rst_n) begin
            age = 0; mem_rd_ack = 1'b0;
        end else if (mem_rd_req && !mem_rd_ack) begin
            age = age + 1;
            if (age == 2) begin mem_rd_ack = 1'b1; rd_count = rd_count + 1; end
        end else begin
            age = 0; mem_rd_ack = 1'b0;
        end
    end

    // Watchdog
    always @(negedge clk) begin
        cyc_cnt = cyc_cnt + 1;
        if (cyc_cnt > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected <= %0d", cyc_cnt, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset outputs", {15'd0, done, ea, wb_en, illegal}, 32'd0);
        check("R10 reset req/cyc", {27'd0, mem_rd_req, extra_cyc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            int rd0;
            logic exp_rd;
            rd0 = rd_count;
            postbyte = VECS[i].pb; offset = VECS[i].off;
            acc_a = VECS[i].a; acc_b = VECS[i].b; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            exp_rd = VECS[i].pb[7] & VECS[i].pb[4] & !VECS[i].ill;
            n_chk = n_chk + 1;
            if (!done || ea !== VECS[i].ea || wb_en !== VECS[i].wb ||
                extra_cyc !== VECS[i].cyc || illegal !== VECS[i].ill ||
                (VECS[i].wb && (wb_val !== VECS[i].wbv || wb_sel !== VECS[i].pb[6:5])) ||
                ((rd_count != rd0) !== exp_rd)) begin
                n_fail = n_fail + 1;
                $display("FAIL R%0d vec %0d pb %h: actual done=%b ea=%h wb=%b/%h/%0d cyc=%0d ill=%b rd=%0d expected ea=%h wb=%b/%h cyc=%0d ill=%b rd=%b",
                         VECS[i].req, i, VECS[i].pb, done, ea, wb_en, wb_val, wb_sel,
                         extra_cyc, illegal, rd_count - rd0, VECS[i].ea, VECS[i].wb,
                         VECS[i].wbv, VECS[i].cyc, VECS[i].ill, exp_rd);
            end
            @(negedge clk);
        end

        // R9 direct result on the first edge after start
        postbyte = 8'h84; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 direct latency", {15'd0, done, ea}, {15'd0, 1'b1, PX});
        @(negedge clk);
        check("R9 done single cycle", {31'd0, done}, 32'd0);

        // R9 start ignored while a read is pending
        postbyte = 8'h94; start = 1'b1;
        @(negedge clk);
        postbyte = 8'hA4; // ,Y would give 2000 if accepted
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R9 busy start ignored ea", {16'd0, ea}, {16'd0, 16'hB5A5});
        @(negedge clk);
        check("R9 no second result", {30'd0, done, mem_rd_req}, 32'd0);

        // R10 reset during a pending read
        postbyte = 8'h94; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 request raised", {31'd0, mem_rd_req}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset clears pending read", {30'd0, mem_rd_req, done}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10 no late result", {31'd0, done}, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule